// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window, 256 bytes wide, placed between a host processor and a service controller. The host posts a request by filling a 16-byte outgoing data buffer and then writing one command word. That write latches the command fields and marks the mailbox busy. It also sends a one-cycle request pulse to the controller. The controller reads the outgoing data and the latched fields, places any reply in a 16-byte incoming buffer, and then strobes completion together with an error flag and an error code.

The host polls the status word until busy returns to zero and then checks the error flag. The incoming buffer contents are meaningful only when that flag is clear. A command can also ask to be told when it finishes. In that case the block emits a single-cycle host interrupt on completion, and the host never has to acknowledge or clear it. Host reads are combinational from the byte address; writes take effect on the clock edge.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, busy, error, error code, latched command fields, both buffers and both interrupt outputs are zero. The status word then reads back only the initiator id in bits 15:8.
- R2: The command word is decoded as command code in bits 7:0, completion-interrupt request in bit 8, sub-command id in bits 15:12 and data byte count in bits 23:16. Bits 11:9 and 31:24 are ignored. The latched fields appear on the controller outputs.
- R3: A host write to the command word (byte offset 0x00) while idle sets busy on the next cycle. It also clears error and error code, and pulses `ctl_irq` high for exactly one cycle.
- R4: The status word at offset 0x04 reads busy in bit 0, error in bit 1, the sub-command id of the current command in bits 7:4, the initiator id in bits 15:8 and the error code in bits 23:16. All other bits read zero.
- R5: A controller completion strobe while busy clears busy on the next cycle. On that same edge it latches `ctl_err` into the error bit and `ctl_err_code` into the error code.
- R6: On the cycle after a completion, `host_irq` is high for exactly one cycle if the finished command had bit 8 set. If that bit was clear, `host_irq` stays low.
- R7: A command write while busy is ignored. The latched fields are unchanged and no `ctl_irq` pulse is produced.
- R8: Host writes to offsets 0x80 to 0x8F fill the outgoing buffer, one 32-bit word per aligned address. The controller reads that buffer by word index. Host reads of the command word, of the outgoing buffer and of unmapped offsets return zero.
- R9: The controller writes the incoming buffer by word index, and the host reads it at offsets 0x90 to 0x9F. Host writes to that range, and to the status word, change nothing.
- R10: A completion strobe while idle is ignored. Busy, error, error code and `host_irq` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_addr | input | 8 | Host byte offset in the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from `host_addr` |
| host_irq | output | 1 | Completion pulse toward host |
| ctl_irq | output | 1 | New-command pulse toward controller |
| ctl_cmd_code | output | 8 | Latched command code |
| ctl_cmd_ioc | output | 1 | Latched completion-interrupt request |
| ctl_cmd_sub | output | 4 | Latched sub-command id |
| ctl_cmd_size | output | 8 | Latched data byte count |
| ctl_wbuf_idx | input | IDX_W | Outgoing buffer word index read by controller |
| ctl_wbuf_rdata | output | 32 | Outgoing buffer word |
| ctl_rbuf_we | input | 1 | Incoming buffer write enable |
| ctl_rbuf_idx | input | IDX_W | Incoming buffer word index |
| ctl_rbuf_wdata | input | 32 | Incoming buffer write data |
| ctl_done | input | 1 | Completion strobe |
| ctl_err | input | 1 | Error flag presented with completion |
| ctl_err_code | input | 8 | Error code presented with completion |

## Verification
The bench builds the block with four buffer words, so every aligned address in both 16-byte ranges is live. It uses a non-zero initiator id (0x3C) so the constant status field can be told apart from the dynamic ones. It selects the reset-cleared buffer variant so buffer reads are defined before they are written. With these values the bench reaches buffer boundary offsets, collisions of a command write with a completion in the same cycle, and stray completions while idle.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

   localparam logic [7:0] CMD_OFS  = 8'h00;
   localparam logic [7:0] STAT_OFS = 8'h04;
   localparam logic [7:0] WBUF_OFS = 8'h80;
   localparam logic [7:0] RBUF_OFS = 8'h90;
   localparam int unsigned MAX_BUF_WORDS = 4;

   typedef enum logic [2:0] {
      RGN_NONE, RGN_CMD, RGN_STAT, RGN_WBUF, RGN_RBUF
   } region_e;

   typedef struct packed {
      logic [7:0] size;
      logic [3:0] sub;
      logic       ioc;
      logic [7:0] code;
   } cmd_fields_t;

   typedef struct packed {
      logic [7:0] rsv_hi;
      logic [7:0] err_code;
      logic [7:0] initiator;
      logic [3:0] cmd_id;
      logic [1:0] rsv_lo;
      logic       err;
      logic       busy;
   } stat_word_t;

endpackage

// File: rtl/ipc_mbx_decode.sv
module ipc_mbx_decode
   import ipc_mbx_pkg::*;
#(
   parameter int unsigned BUF_WORDS = 4,
   parameter int unsigned IDX_W     = 2
) (
   input  logic [7:0]       addr,
   output region_e          region,
   output logic [IDX_W-1:0] word_idx
);
   localparam logic [8:0] WB_END = 9'(WBUF_OFS) + 9'(4 * BUF_WORDS);
   localparam logic [8:0] RB_END = 9'(RBUF_OFS) + 9'(4 * BUF_WORDS);

   logic [7:0] off_w, off_r;
   assign off_w = addr - WBUF_OFS;
   assign off_r = addr - RBUF_OFS;

   always_comb begin
      region   = RGN_NONE;
      word_idx = '0;
      if (addr[7:2] == CMD_OFS[7:2]) begin
         region = RGN_CMD;
      end else if (addr[7:2] == STAT_OFS[7:2]) begin
         region = RGN_STAT;
      end else if (addr >= WBUF_OFS && {1'b0, addr} < WB_END) begin
         region   = RGN_WBUF;
         word_idx = off_w[IDX_W+1:2];
      end else if (addr >= RBUF_OFS && {1'b0, addr} < RB_END) begin
         region   = RGN_RBUF;
         word_idx = off_r[IDX_W+1:2];
      end
   end
endmodule

// File: rtl/ipc_mbx_bank.sv
module ipc_mbx_bank #(
   parameter int unsigned WORDS          = 4,
   parameter int unsigned IDX_W          = 2,
   parameter int unsigned DW             = 32,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [DW-1:0]    wdata,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [DW-1:0]    rdata
);
   logic [WORDS-1:0][DW-1:0] words;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic          hit;
      logic [DW-1:0] q;
      assign hit = we && (32'(wr_idx) == w);
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wdata;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) q <= wdata;
         end
      end
      assign words[w] = q;
   end

   assign rdata = (32'(rd_idx) < WORDS) ? words[rd_idx] : '0;
endmodule

// File: rtl/ipc_mbx_handshake.sv
module ipc_mbx_handshake
   import ipc_mbx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_wr,
   input  cmd_fields_t cmd_in,
   input  logic        ctl_done,
   input  logic        ctl_err,
   input  logic [7:0]  ctl_err_code,
   output logic        busy,
   output logic        err,
   output logic [7:0]  err_code,
   output cmd_fields_t cmd_q,
   output logic        ctl_irq,
   output logic        host_irq
);
   logic accept, finish;
   assign accept = cmd_wr && !busy;
   assign finish = ctl_done && busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         err      <= 1'b0;
         err_code <= '0;
         cmd_q    <= '0;
         ctl_irq  <= 1'b0;
         host_irq <= 1'b0;
      end else begin
         ctl_irq  <= accept;
         host_irq <= finish && cmd_q.ioc;
         if (accept) begin
            cmd_q    <= cmd_in;
            busy     <= 1'b1;
            err      <= 1'b0;
            err_code <= '0;
         end else if (finish) begin
            busy     <= 1'b0;
            err      <= ctl_err;
            err_code <= ctl_err_code;
         end
      end
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import ipc_mbx_pkg::*;
#(
   parameter int unsigned BUF_WORDS  = 4,
   parameter logic [7:0]  HOST_ID    = 8'h01,
   parameter bit          CLEAR_BUFS = 1'b1,
   localparam int unsigned IDX_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic [7:0]       host_addr,
   input  logic [31:0]      host_wdata,
   output logic [31:0]      host_rdata,
   output logic             host_irq,
   output logic             ctl_irq,
   output logic [7:0]       ctl_cmd_code,
   output logic             ctl_cmd_ioc,
   output logic [3:0]       ctl_cmd_sub,
   output logic [7:0]       ctl_cmd_size,
   input  logic [IDX_W-1:0] ctl_wbuf_idx,
   output logic [31:0]      ctl_wbuf_rdata,
   input  logic             ctl_rbuf_we,
   input  logic [IDX_W-1:0] ctl_rbuf_idx,
   input  logic [31:0]      ctl_rbuf_wdata,
   input  logic             ctl_done,
   input  logic             ctl_err,
   input  logic [7:0]       ctl_err_code
);
   if (BUF_WORDS < 1 || BUF_WORDS > MAX_BUF_WORDS) begin : g_bad_words
      $error("ipc_mailbox: BUF_WORDS must lie in 1..%0d", MAX_BUF_WORDS);
   end

   region_e          region;
   logic [IDX_W-1:0] host_idx;
   logic             busy_q, err_q;
   logic [7:0]       code_q;
   cmd_fields_t      cmd_in, cmd_q;
   stat_word_t       stat;
   logic [31:0]      rbuf_rdata;

   ipc_mbx_decode #(.BUF_WORDS(BUF_WORDS), .IDX_W(IDX_W)) u_dec (
      .addr(host_addr), .region(region), .word_idx(host_idx)
   );

   assign cmd_in = '{size: host_wdata[23:16], sub: host_wdata[15:12],
                     ioc: host_wdata[8], code: host_wdata[7:0]};

   ipc_mbx_handshake u_hs (
      .clk(clk), .rst_n(rst_n),
      .cmd_wr(host_wr && region == RGN_CMD), .cmd_in(cmd_in),
      .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_err_code(ctl_err_code),
      .busy(busy_q), .err(err_q), .err_code(code_q), .cmd_q(cmd_q),
      .ctl_irq(ctl_irq), .host_irq(host_irq)
   );

   ipc_mbx_bank #(.WORDS(BUF_WORDS), .IDX_W(IDX_W), .DW(32),
                  .CLEAR_ON_RESET(CLEAR_BUFS)) u_wbuf (
      .clk(clk), .rst_n(rst_n),
      .we(host_wr && region == RGN_WBUF), .wr_idx(host_idx), .wdata(host_wdata),
      .rd_idx(ctl_wbuf_idx), .rdata(ctl_wbuf_rdata)
   );

   ipc_mbx_bank #(.WORDS(BUF_WORDS), .IDX_W(IDX_W), .DW(32),
                  .CLEAR_ON_RESET(CLEAR_BUFS)) u_rbuf (
      .clk(clk), .rst_n(rst_n),
      .we(ctl_rbuf_we), .wr_idx(ctl_rbuf_idx), .wdata(ctl_rbuf_wdata),
      .rd_idx(host_idx), .rdata(rbuf_rdata)
   );

   assign stat = '{rsv_hi: 8'h00, err_code: code_q, initiator: HOST_ID,
                   cmd_id: cmd_q.sub, rsv_lo: 2'b00, err: err_q, busy: busy_q};

   always_comb begin
      case (region)
         RGN_STAT: host_rdata = stat;
         RGN_RBUF: host_rdata = rbuf_rdata;
         default:  host_rdata = '0;
      endcase
   end

   assign ctl_cmd_code = cmd_q.code;
   assign ctl_cmd_ioc  = cmd_q.ioc;
   assign ctl_cmd_sub  = cmd_q.sub;
   assign ctl_cmd_size = cmd_q.size;
endmodule

// File: rtl/ipc_mbx_chk.sv
module ipc_mbx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       host_wr,
   input logic [5:0] host_word,
   input logic       ctl_done,
   input logic       ctl_err,
   input logic       ctl_irq,
   input logic       host_irq,
   input logic       busy,
   input logic       err,
   input logic       ioc,
   input logic [7:0] cmd_code
);
   logic cmd_hit;
   assign cmd_hit = host_wr && (host_word == 6'd0);

   p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hit && !busy) |=> (busy && ctl_irq));

   p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_irq |=> !ctl_irq);

   p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hit && busy) |=> (!ctl_irq && $stable(cmd_code)));

   p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctl_done) |=> (!busy && err == $past(ctl_err)));

   p_irq_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctl_done && ioc) |=> host_irq);

   p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> $past(busy && ctl_done && ioc));

   p_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ctl_done && !cmd_hit) |=> (!busy && !host_irq && $stable(err)));
endmodule

bind ipc_mailbox ipc_mbx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_word(host_addr[7:2]),
   .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_irq(ctl_irq),
   .host_irq(host_irq), .busy(busy_q), .err(err_q), .ioc(ctl_cmd_ioc),
   .cmd_code(ctl_cmd_code)
);

// File: tb/tb_ipc_mailbox.sv
module tb_ipc_mailbox;
   localparam int unsigned BW  = 4;
   localparam logic [7:0]  HID = 8'h3C;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_irq, ctl_irq, ctl_cmd_ioc;
   logic [7:0]  ctl_cmd_code, ctl_cmd_size;
   logic [3:0]  ctl_cmd_sub;
   logic [1:0]  ctl_wbuf_idx = '0;
   logic [31:0] ctl_wbuf_rdata;
   logic        ctl_rbuf_we = 1'b0;
   logic [1:0]  ctl_rbuf_idx = '0;
   logic [31:0] ctl_rbuf_wdata = '0;
   logic        ctl_done = 1'b0, ctl_err = 1'b0;
   logic [7:0]  ctl_err_code = '0;

   ipc_mailbox #(.BUF_WORDS(BW), .HOST_ID(HID), .CLEAR_BUFS(1'b1)) dut (.*);

   int    n_vec = 0, n_bad = 0;
   bit    finished = 0;
   string phase = "reset";

   // behavioural reference state
   bit          m_busy, m_err, m_cirq, m_hirq;
   logic [7:0]  m_code;
   logic [31:0] m_cmd;
   logic [31:0] m_wb [4];
   logic [31:0] m_rb [4];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s (%s) actual=%h expected=%h", tag, phase, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rdata();
      if (host_addr[7:2] == 6'd1)
         return {8'h00, m_code, HID, m_cmd[15:12], 2'b00, m_err, m_busy};
      if (host_addr >= 8'h90 && host_addr < 8'hA0) return m_rb[host_addr[3:2]];
      return 32'h0;
   endfunction

   task automatic compare_all();
      string rtag;
      if (host_addr[7:2] == 6'd1) rtag = "R4 R5 status";
      else if (host_addr >= 8'h90 && host_addr < 8'hA0) rtag = "R9 incoming read";
      else rtag = "R8 zero read";
      chk("R3 ctl_irq", 32'(ctl_irq), 32'(m_cirq));
      chk("R6 host_irq", 32'(host_irq), 32'(m_hirq));
      chk(rtag, host_rdata, exp_rdata());
      chk("R2 command fields",
          32'({ctl_cmd_size, ctl_cmd_sub, ctl_cmd_ioc, ctl_cmd_code}),
          32'({m_cmd[23:16], m_cmd[15:12], m_cmd[8], m_cmd[7:0]}));
      chk("R8 outgoing buffer", ctl_wbuf_rdata, m_wb[ctl_wbuf_idx]);
   endtask

   task automatic cycle();
      bit acc, fin;
      #1;
      compare_all();
      @(posedge clk);
      acc = host_wr && host_addr[7:2] == 6'd0 && !m_busy;
      fin = ctl_done && m_busy;
      m_cirq = acc;
      m_hirq = fin && m_cmd[8];
      if (acc) begin
         m_cmd = host_wdata; m_busy = 1; m_err = 0; m_code = 0;
      end else if (fin) begin
         m_busy = 0; m_err = ctl_err; m_code = ctl_err_code;
      end
      if (host_wr && host_addr >= 8'h80 && host_addr < 8'h90)
         m_wb[host_addr[3:2]] = host_wdata;
      if (ctl_rbuf_we) m_rb[ctl_rbuf_idx] = ctl_rbuf_wdata;
      @(negedge clk);
   endtask

   task automatic hwrite(logic [7:0] a, logic [31:0] d);
      host_wr = 1; host_addr = a; host_wdata = d;
      cycle();
      host_wr = 0;
   endtask

   task automatic hread(logic [7:0] a);
      host_addr = a;
      cycle();
   endtask

   task automatic cdone(logic e, logic [7:0] c);
      ctl_done = 1; ctl_err = e; ctl_err_code = c;
      cycle();
      ctl_done = 0;
   endtask

   task automatic creply(logic [1:0] i, logic [31:0] d);
      ctl_rbuf_we = 1; ctl_rbuf_idx = i; ctl_rbuf_wdata = d;
      cycle();
      ctl_rbuf_we = 0;
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         n_bad++;
         $display("FAIL all requirements: watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      m_busy = 0; m_err = 0; m_cirq = 0; m_hirq = 0; m_code = 0; m_cmd = 0;
      for (int i = 0; i < 4; i++) begin m_wb[i] = 0; m_rb[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: status holds only the initiator id after reset
      host_addr = 8'h04; #1;
      chk("R1 status after reset", host_rdata, {16'h0, HID, 8'h00});
      chk("R1 irqs after reset", 32'({host_irq, ctl_irq}), 32'h0);
      for (int i = 0; i < 4; i++) hread(8'h90 + 8'(4 * i));

      phase = "fill outgoing R8";
      for (int i = 0; i < 4; i++) hwrite(8'h80 + 8'(4 * i), 32'hA0B0_0000 + 32'(i));
      for (int i = 0; i < 4; i++) begin ctl_wbuf_idx = 2'(i); hread(8'h80 + 8'(4 * i)); end
      hread(8'h00); hread(8'h40); hread(8'hFC);

      phase = "command with completion irq R3 R2";
      hwrite(8'h00, 32'hFF10_21F4);       // code F4, ioc 1, sub 2, size 10, reserved set
      hread(8'h04); hread(8'h04);
      phase = "write while busy R7";
      hwrite(8'h00, 32'h0003_30AA);
      hread(8'h04);
      phase = "reply and finish R5 R6";
      creply(2'd0, 32'h1122_3344); creply(2'd3, 32'h5566_7788);
      cdone(1'b0, 8'h00);
      hread(8'h04); hread(8'h90); hread(8'h9C);

      phase = "command without irq, error R5 R6";
      hwrite(8'h00, 32'h0004_5077);
      cdone(1'b1, 8'h5A);
      hread(8'h04); hread(8'h04);

      phase = "stray completion R10";
      cdone(1'b0, 8'h11);
      hread(8'h04);

      phase = "ignored host writes R9";
      hwrite(8'h90, 32'hDEAD_BEEF); hwrite(8'h04, 32'hFFFF_FFFF);
      hread(8'h90); hread(8'h04);

      phase = "command write meets completion R7 R5";
      hwrite(8'h00, 32'h0000_0101);
      host_wr = 1; host_addr = 8'h00; host_wdata = 32'h0000_0202;
      ctl_done = 1; ctl_err = 0; ctl_err_code = 8'h00;
      cycle();
      host_wr = 0; ctl_done = 0;
      hread(8'h04); hread(8'h04);

      phase = "random";
      for (int n = 0; n < 4000; n++) begin
         int sel;
         sel = int'($urandom_range(0, 5));
         host_wr = ($urandom_range(0, 3) == 0);
         case (sel)
            0: host_addr = 8'h00;
            1: host_addr = 8'h04;
            2: host_addr = 8'h80 + 8'($urandom_range(0, 15));
            3: host_addr = 8'h90 + 8'($urandom_range(0, 15));
            default: host_addr = 8'($urandom);
         endcase
         host_wdata     = $urandom;
         ctl_done       = ($urandom_range(0, 6) == 0);
         ctl_err        = 1'($urandom);
         ctl_err_code   = 8'($urandom);
         ctl_rbuf_we    = ($urandom_range(0, 4) == 0);
         ctl_rbuf_idx   = 2'($urandom);
         ctl_rbuf_wdata = $urandom;
         ctl_wbuf_idx   = 2'($urandom);
         cycle();
      end
      host_wr = 0; ctl_done = 0; ctl_rbuf_we = 0;
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule